// File: doc/BRIEF.md
# Self-Programming Flash Access Controller

This block stands between a small processor core and an on-chip flash that holds its program. It serves instruction fetches through a valid/ready stream. It also takes program-memory commands from the core: fill a word of the page buffer, erase a page, write the page buffer into a page, or read a word as data. Each command carries the program counter of the instruction that issued it. Permission depends on where that instruction sits. Only code in the boot section may change the flash. Code in either section may be barred from reading the other section. Each section has its own write-block bit.

The flash is cut in two ways. The boundary between the application section and the boot section is movable and is chosen by a static size-select input. A second boundary is fixed and separates the lower three quarters, which can be programmed while the core runs, from the top quarter. When the top quarter is being programmed, the core is stalled. When a page in the lower region is erased or written, the core keeps fetching from the top quarter. Fetches into the region being programmed are held back by deasserting `fetch_ready`. The flash array is a behavioural model. Every erase or write takes `OP_CYCLES` clock cycles.

The fetch request stream follows the normal valid/ready rule. An address is taken in a cycle where `fetch_valid` and `fetch_ready` are both high. While `fetch_ready` is low, the requester holds its request. The response stream (`rsp_valid`/`rsp_data`) has no ready signal, so the receiver must accept each response in the cycle it appears. Commands are plain control pins and are never back-pressured. A command that cannot be carried out is reported through `cmd_deny` or `cmd_err`.

Top module: `spm_flash_ctrl`

## Requirements
- R1: A fill, erase or write command whose `cmd_pc` lies below the boot boundary has no effect on the flash or the page buffer, and `cmd_deny` is high in the following cycle.
- R2: A fill, erase or write command issued from the boot section may target any page, including pages in the boot section.
- R3: With depth D, `boot_sel` values 0, 1, 2 and 3 place the boot boundary at D-D/4, D-D/8, D-D/16 and D-D/32. An address at or above the boundary is in the boot section.
- R4: Lock bit 0 of `app_lock` blocks erase and write of application pages. Lock bit 0 of `boot_lock` blocks erase and write of boot pages. A blocked command raises `cmd_deny` and changes nothing.
- R5: Lock bit 1 of a section blocks read commands into that section when they are issued from the other section. A blocked read raises `cmd_deny` and gives no `rd_valid`. Reads from inside the same section are always allowed. An allowed read returns `rd_valid` with the word one cycle after the command.
- R6: An erase or write whose page lies below D-D/4 holds `busy_rww` high for exactly `OP_CYCLES` cycles. During that time, fetches at or above D-D/4 are accepted and fetches below it see `fetch_ready` low.
- R7: An erase or write whose page lies at or above D-D/4 holds `cpu_stall` high for exactly `OP_CYCLES` cycles, with `fetch_ready` low for every address.
- R8: `op_done` is high for exactly one cycle, in the first cycle after `busy_rww` or `cpu_stall` falls.
- R9: Any command that arrives while an erase or write is in progress is ignored, and `cmd_err` is high for one cycle.
- R10: The command codes are 0 fill, 1 erase, 2 write and 3 read. Fill stores a word in the page buffer at the low `PAGE_W` address bits. Write copies the whole buffer into the page and then resets the buffer to all ones. Erase sets every word of the page to all ones. Reads are by single word.
- R11: An accepted fetch gives `rsp_valid` with the addressed word in the next cycle, and at no other time.
- R12: After reset the controller is idle and every flash word and buffer word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 2 | Boot section size select (static) |
| app_lock | input | 2 | Application section protection: bit0 write-block, bit1 cross-read block |
| boot_lock | input | 2 | Boot section protection: bit0 write-block, bit1 cross-read block |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (0 fill, 1 erase, 2 write, 3 read) |
| cmd_pc | input | ADDR_W | Program counter of the issuing instruction |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Fill data |
| cmd_deny | output | 1 | Previous-cycle command refused by permission |
| cmd_err | output | 1 | Previous-cycle command refused because an operation was in progress |
| rd_valid | output | 1 | Read command result valid |
| rd_data | output | DATA_W | Read command result |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request can be accepted |
| fetch_addr | input | ADDR_W | Fetch word address |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_data | output | DATA_W | Fetch response word |
| busy_rww | output | 1 | Lower-region programming in progress |
| cpu_stall | output | 1 | Top-region programming in progress, core stalled |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The main function is driven with fills and writes issued from boot code into both the lower region and the top quarter. These show whether the stall or busy choice follows the target page and not the issuing address. Fetches are issued in the middle of each operation, both inside and outside the region being programmed, to tell the refusal rule apart from a full stall. The program counter is placed one word on each side of the boundary for several size-select values, which exposes off-by-one and size-decoding faults. Reads are issued from both sections with each lock bit set and clear, which separates the same-section rule from the cross-section rule.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } spm_op_e;

  // protection bit positions inside a section's lock field
  localparam int LK_WR  = 0;
  localparam int LK_XRD = 1;

  // fixed split: top quarter of the array cannot be read while it is programmed
  function automatic logic in_top_quarter(input logic [1:0] msbs);
    return msbs == 2'b11;
  endfunction
endpackage

// File: rtl/spm_boot_decode.sv
module spm_boot_decode #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        boot_sel,
  output logic              in_boot
);
  localparam int          DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] boot_size;
  logic [ADDR_W:0] boot_base;

  always_comb begin
    boot_size = FULL >> (3'd2 + 3'(boot_sel));
    boot_base = FULL - boot_size;
    in_boot   = {1'b0, addr} >= boot_base;
  end
endmodule

// File: rtl/spm_policy.sv
module spm_policy
  import spm_pkg::*;
(
  input  logic       cmd_valid,
  input  spm_op_e    op,
  input  logic       pc_boot,
  input  logic       tgt_boot,
  input  logic [1:0] app_lock,
  input  logic [1:0] boot_lock,
  input  logic       engine_active,
  output logic       go_fill,
  output logic       go_erase,
  output logic       go_write,
  output logic       go_read,
  output logic       deny,
  output logic       err
);
  logic [1:0] tgt_lock;
  logic       modifies;
  logic       allowed;

  always_comb begin
    tgt_lock = tgt_boot ? boot_lock : app_lock;
    modifies = (op == OP_ERASE) || (op == OP_WRITE);
    unique case (op)
      OP_FILL:  allowed = pc_boot;
      OP_ERASE,
      OP_WRITE: allowed = pc_boot && !tgt_lock[LK_WR];
      OP_READ:  allowed = (pc_boot == tgt_boot) || !tgt_lock[LK_XRD];
      default:  allowed = 1'b0;
    endcase
    err      = cmd_valid && engine_active;
    deny     = cmd_valid && !engine_active && !allowed;
    go_fill  = cmd_valid && !engine_active && allowed && (op == OP_FILL);
    go_erase = cmd_valid && !engine_active && allowed && (op == OP_ERASE);
    go_write = cmd_valid && !engine_active && allowed && (op == OP_WRITE);
    go_read  = cmd_valid && !engine_active && allowed && (op == OP_READ);
  end

  // R1
  app_no_modify_chk: assert final (!(modifies && !pc_boot && (go_erase || go_write)));
endmodule

// File: rtl/spm_flash_model.sv
module spm_flash_model #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 3,
  parameter int OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_fill,
  input  logic              go_erase,
  input  logic              go_write,
  input  logic              go_read,
  input  logic              tgt_top,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              fetch_take,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              engine_active,
  output logic              engine_top,
  output logic              op_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_WORDS = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(OP_CYCLES);

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pbuf [PAGE_WORDS];
  logic [CNT_W-1:0]  cnt;
  logic [PG_W-1:0]   page_q;
  logic              is_write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
      cnt           <= '0;
      page_q        <= '0;
      is_write_q    <= 1'b0;
      engine_active <= 1'b0;
      engine_top    <= 1'b0;
      op_done       <= 1'b0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
    end else begin
      op_done   <= 1'b0;
      rsp_valid <= fetch_take;
      rd_valid  <= go_read;
      if (fetch_take) rsp_data <= mem[fetch_addr];
      if (go_read)    rd_data  <= mem[cmd_addr];
      if (go_fill)    pbuf[cmd_addr[PAGE_W-1:0]] <= cmd_wdata;
      if (go_erase || go_write) begin
        engine_active <= 1'b1;
        engine_top    <= tgt_top;
        is_write_q    <= go_write;
        page_q        <= cmd_addr[ADDR_W-1:PAGE_W];
        cnt           <= CNT_W'(OP_CYCLES - 1);
      end else if (engine_active) begin
        if (cnt == '0) begin
          engine_active <= 1'b0;
          engine_top    <= 1'b0;
          op_done       <= 1'b1;
          for (int w = 0; w < PAGE_WORDS; w++) begin
            mem[{page_q, PAGE_W'(w)}] <= is_write_q ? pbuf[w] : '1;
            if (is_write_q) pbuf[w] <= '1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_done) |-> $past(engine_active));
  // R9
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_active && (go_erase || go_write || go_fill || go_read)) |-> 1'b0);
endmodule

// File: rtl/spm_flash_ctrl.sv
module spm_flash_ctrl
  import spm_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 3,
  parameter int OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sel,
  input  logic [1:0]        app_lock,
  input  logic [1:0]        boot_lock,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_pc,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_deny,
  output logic              cmd_err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy_rww,
  output logic              cpu_stall,
  output logic              op_done
);
  localparam int N_DEC = 2;

  logic [ADDR_W-1:0] dec_addr [N_DEC];
  logic [N_DEC-1:0]  dec_boot;
  logic go_fill, go_erase, go_write, go_read, deny_c, err_c;
  logic engine_active, engine_top, fetch_top, tgt_top, fetch_take;

  assign dec_addr[0] = cmd_pc;
  assign dec_addr[1] = cmd_addr;

  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    spm_boot_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (dec_addr[g]),
      .boot_sel (boot_sel),
      .in_boot  (dec_boot[g])
    );
  end

  assign tgt_top   = in_top_quarter(cmd_addr[ADDR_W-1:ADDR_W-2]);
  assign fetch_top = in_top_quarter(fetch_addr[ADDR_W-1:ADDR_W-2]);

  spm_policy u_policy (
    .cmd_valid     (cmd_valid),
    .op            (spm_op_e'(cmd_op)),
    .pc_boot       (dec_boot[0]),
    .tgt_boot      (dec_boot[1]),
    .app_lock      (app_lock),
    .boot_lock     (boot_lock),
    .engine_active (engine_active),
    .go_fill       (go_fill),
    .go_erase      (go_erase),
    .go_write      (go_write),
    .go_read       (go_read),
    .deny          (deny_c),
    .err           (err_c)
  );

  assign busy_rww    = engine_active && !engine_top;
  assign cpu_stall   = engine_active && engine_top;
  assign fetch_ready = !cpu_stall && !(busy_rww && !fetch_top);
  assign fetch_take  = fetch_valid && fetch_ready;

  spm_flash_model #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .OP_CYCLES(OP_CYCLES)
  ) u_flash (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_fill       (go_fill),
    .go_erase      (go_erase),
    .go_write      (go_write),
    .go_read       (go_read),
    .tgt_top       (tgt_top),
    .cmd_addr      (cmd_addr),
    .cmd_wdata     (cmd_wdata),
    .fetch_take    (fetch_take),
    .fetch_addr    (fetch_addr),
    .engine_active (engine_active),
    .engine_top    (engine_top),
    .op_done       (op_done),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_deny <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_deny <= deny_c;
      cmd_err  <= err_c;
    end
  end

  // R1
  app_pc_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !dec_boot[0] && (cmd_op != 2'd3) && !busy_rww && !cpu_stall)
      |=> (!busy_rww && !cpu_stall && cmd_deny));
  // R6
  rww_fetch_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rww && fetch_valid && fetch_ready) |-> fetch_top);
  // R7
  stall_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !rsp_valid || $past(!cpu_stall));
  // R9
  err_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(busy_rww || cpu_stall));
  // R11
  rsp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(fetch_valid && fetch_ready));
endmodule

// File: tb/test_spm_flash_ctrl.sv
module test_spm_flash_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 10;
  localparam int DW  = 16;
  localparam int OPC = 8;
  localparam int TOPB = 768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] boot_sel = 2'd3, app_lock = 2'd0, boot_lock = 2'd0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_pc = '0, cmd_addr = '0, fetch_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic fetch_valid = 1'b0;
  logic cmd_deny, cmd_err, rd_valid, fetch_ready, rsp_valid, busy_rww, cpu_stall, op_done;
  logic [DW-1:0] rd_data, rsp_data;

  int total = 0, bad = 0, run = 0;
  logic [DW-1:0] mdl [1024];
  logic [DW-1:0] pb [8];
  logic [DW-1:0] fq[$];
  logic [DW-1:0] rq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_flash_ctrl i_spm_flash_ctrl (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: fetch and read responses against queued expectations
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (fq.size() == 0) chk("R11", "unexpected rsp_valid", 1, 0);
      else chk("R11", "rsp_data", rsp_data, fq.pop_front());
    end
    if (rst_n && rd_valid) begin
      if (rq.size() == 0) chk("R5", "unexpected rd_valid", 1, 0);
      else chk("R5", "rd_data", rd_data, rq.pop_front());
    end
    if (rst_n) begin
      if (busy_rww || cpu_stall) run++;
      else if (run != 0) begin
        chk("R6", "operation length", run, OPC);
        chk("R8", "op_done after op", op_done, 1);
        run = 0;
      end else chk("R8", "op_done idle", op_done, 0);
    end
  end

  task automatic fetch(input int a, input logic exp_rdy, input string req);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = AW'(a); #1;
    chk(req, "fetch_ready", fetch_ready, exp_rdy);
    if (fetch_ready) fq.push_back(mdl[a]);
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input int pc, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = AW'(pc); cmd_addr = AW'(a); cmd_wdata = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  // driver: issues a command and records its expected effect
  task automatic spm(input logic [1:0] op, input int pc, input int a,
                     input logic [DW-1:0] d, input logic ok, input string req);
    if (op == 2'd3 && ok) rq.push_back(mdl[a]);
    cmd(op, pc, a, d);
    chk(req, "cmd_deny", cmd_deny, !ok);
    if (ok && op == 2'd0) pb[a % 8] = d;
    if (ok && (op == 2'd1 || op == 2'd2)) begin
      chk(req, "busy_rww", busy_rww, a < TOPB);
      chk(req, "cpu_stall", cpu_stall, a >= TOPB);
      for (int w = 0; w < 8; w++) begin
        mdl[(a / 8) * 8 + w] = (op == 2'd2) ? pb[w] : '1;
        if (op == 2'd2) pb[w] = '1;
      end
    end
    if (!ok || op == 2'd0 || op == 2'd3) begin
      chk(req, "idle after command", busy_rww | cpu_stall, 0);
    end
  endtask

  task automatic wait_idle();
    while (busy_rww || cpu_stall) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '1;
    for (int i = 0; i < 8; i++) pb[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "busy_rww", busy_rww, 0);
    chk("R12", "cpu_stall", cpu_stall, 0);
    chk("R12", "op_done", op_done, 0);
    fetch(5, 1, "R12");
    fetch(1020, 1, "R12");

    // R10/R6: fill and write a lower-region page from boot code
    for (int i = 0; i < 8; i++) spm(2'd0, 1000, 'h40 + i, 16'hA000 + DW'(i), 1, "R10");
    spm(2'd2, 1000, 'h40, 0, 1, "R6");
    fetch(800, 1, "R6");
    fetch('h10, 0, "R6");
    cmd(2'd3, 1000, 'h10, 0);
    chk("R9", "cmd_err", cmd_err, 1);
    @(negedge clk);
    chk("R9", "cmd_err one cycle", cmd_err, 0);
    wait_idle();
    for (int i = 0; i < 8; i++) fetch('h40 + i, 1, "R10");

    // R1: application code cannot fill or program
    spm(2'd0, 100, 'h80, 16'h1234, 0, "R1");
    spm(2'd2, 100, 'h80, 0, 0, "R1");
    spm(2'd2, 1000, 'h80, 0, 1, "R1");
    wait_idle();
    fetch('h80, 1, "R1");

    // R3: boundary per size select
    spm(2'd2, 970, 'h88, 0, 0, "R3");
    boot_sel = 2'd2;
    spm(2'd2, 960, 'h88, 0, 1, "R3");
    wait_idle();
    spm(2'd1, 959, 'h88, 0, 0, "R3");
    boot_sel = 2'd1;
    spm(2'd1, 895, 'h88, 0, 0, "R3");
    spm(2'd1, 896, 'h88, 0, 1, "R3");
    wait_idle();
    boot_sel = 2'd0;
    spm(2'd1, 767, 'h88, 0, 0, "R3");
    spm(2'd1, 768, 'h88, 0, 1, "R3");
    wait_idle();
    boot_sel = 2'd3;

    // R2/R7: boot code rewrites a page of its own section in the top quarter
    for (int i = 0; i < 8; i++) spm(2'd0, 1000, 1008 + i, 16'hB000 + DW'(i), 1, "R2");
    spm(2'd2, 1000, 1008, 0, 1, "R7");
    fetch(800, 0, "R7");
    fetch('h10, 0, "R7");
    wait_idle();
    for (int i = 0; i < 8; i++) fetch(1008 + i, 1, "R2");

    // R10: erase
    spm(2'd1, 1000, 'h42, 0, 1, "R10");
    wait_idle();
    fetch('h42, 1, "R10");
    fetch('h47, 1, "R10");

    // R4: per-section write block
    boot_lock = 2'b01;
    spm(2'd1, 1000, 1008, 0, 0, "R4");
    spm(2'd1, 1000, 'h48, 0, 1, "R4");
    wait_idle();
    boot_lock = 2'b00; app_lock = 2'b01;
    spm(2'd1, 1000, 'h48, 0, 0, "R4");
    spm(2'd1, 1000, 1008, 0, 1, "R4");
    wait_idle();
    app_lock = 2'b00;
    fetch(1009, 1, "R4");

    // R5: cross-section read blocking
    for (int i = 0; i < 8; i++) spm(2'd0, 1000, 'h60 + i, 16'hC000 + DW'(i), 1, "R5");
    spm(2'd2, 1000, 'h60, 0, 1, "R5");
    wait_idle();
    app_lock = 2'b10;
    spm(2'd3, 1000, 'h61, 0, 0, "R5");
    spm(2'd3, 10, 'h61, 0, 1, "R5");
    app_lock = 2'b00; boot_lock = 2'b10;
    spm(2'd3, 10, 1000, 0, 0, "R5");
    spm(2'd3, 1000, 1000, 0, 1, "R5");
    boot_lock = 2'b00;
    spm(2'd3, 10, 'h63, 0, 1, "R5");

    repeat (4) @(negedge clk);
    chk("R11", "fetch queue drained", fq.size(), 0);
    chk("R5", "read queue drained", rq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule